// File: doc/BRIEF.md
# Chunked Complex Dot-Product Engine

This block forms the complex dot product of a vector with one row of a coefficient matrix. Both operands arrive on their own narrow stream: first the real part of a point, then its imaginary part, one 16-bit word per accepted beat. Each stream fills its own shift register with one chunk of eight points, which is sixteen words. When both chunks are complete, the pair moves into a stage of complex multipliers. A three-level registered adder tree reduces the eight products to one partial sum. An accumulator then adds the partial sums of all chunks of the row.

A 256-point row takes 32 chunk pairs. At the end of a row the block raises a one-cycle result strobe with the 40-bit real and imaginary totals. To multiply a whole matrix, the caller sends the vector again alongside each coefficient row. A stream that has finished a chunk is held off until its partner chunk is also complete, so the two streams always pair up point by point.

Top module: `cmv_engine`

## Requirements
- R1: Each stream accepts one word per cycle in which valid and ready are both high. The word order is: real part of point k at word 2k, imaginary part at word 2k+1. Ready stays high while fewer than 16 words (one eight-point chunk) are buffered on that stream.
- R2: A stream holding a complete chunk keeps its ready low until the other stream also holds a complete chunk. Once the pair is taken, both streams accept words again.
- R3: The result of a row is the sum over all 256 points of vec[k]*coef[k]. Complex multiplication is used: real = vr*cr - vi*ci, imaginary = vr*ci + vi*cr, with 16-bit signed inputs. Each component is exact modulo 2^40 in two's complement.
- R4: Exactly one res_valid pulse, one cycle wide, is produced for every 32 chunk pairs.
- R5: res_valid rises 5 clock edges after the edge that accepts the last word of the row's 32nd chunk pair.
- R6: Each row's result is independent of earlier rows; the accumulator restarts at the first chunk of every row.
- R7: While reset is held and right after it, both ready outputs are high, res_valid is low and both result components are zero.
- R8: Data presented while valid is low has no effect on any result.
- R9: res_re and res_im keep their value between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_valid | input | 1 | Vector stream word valid |
| vec_data | input | 16 | Vector stream word (signed real or imaginary part) |
| vec_ready | output | 1 | Vector stream can accept a word |
| coef_valid | input | 1 | Coefficient stream word valid |
| coef_data | input | 16 | Coefficient stream word (signed real or imaginary part) |
| coef_ready | output | 1 | Coefficient stream can accept a word |
| res_valid | output | 1 | One-cycle strobe: row result ready |
| res_re | output | 40 | Real part of the row result |
| res_im | output | 40 | Imaginary part of the row result |

## Verification
The bench builds the engine with its default parameters: 16-bit words, eight-point chunks, 256-point rows and a 40-bit accumulator. With these values, a row where every part is the most negative input drives the imaginary total to exactly 2^39, which is where the 40-bit accumulator wraps. The default chunk size gives the tree three registered levels, so the five-edge result latency can be checked at a fixed cycle. Random gaps on each stream, and a stream deliberately left alone with a full chunk, exercise both sides of the pairing back-pressure.

// File: rtl/cmv_pkg.sv
// Shared defaults for the chunked complex dot-product engine.
// Assumes: all widths two's complement; chunk size a power of two.
package cmv_pkg;
    localparam int unsigned CMV_DATA_W  = 16;
    localparam int unsigned CMV_CHUNK   = 8;
    localparam int unsigned CMV_POINTS  = 256;
    localparam int unsigned CMV_ACC_W   = 40;

    // Number of adder-tree levels needed to reduce n leaves to one.
    function automatic int unsigned cmv_levels(input int unsigned n);
        int unsigned l;
        l = 0;
        while ((1 << l) < n) l++;
        return l;
    endfunction
endpackage

// File: rtl/cmv_chunk_loader.sv
// Chunk loader: shifts stream words into a register until one full chunk
// (2*CHUNK words, real then imaginary per point) is held, then blocks the
// stream until the consumer takes the chunk.
// Assumes: take is asserted only while full is high.
module cmv_chunk_loader #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHUNK  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    output logic                          in_ready,
    input  logic                          take,
    output logic                          full,
    output logic [2*CHUNK*DATA_W-1:0]     words
);
    localparam int unsigned WORDS = 2 * CHUNK;
    localparam int unsigned CNT_W = $clog2(WORDS + 1);

    logic [CNT_W-1:0]            count;
    logic [WORDS*DATA_W-1:0]     shreg;

    assign full     = (count == CNT_W'(WORDS));
    assign in_ready = (count < CNT_W'(WORDS));
    assign words    = shreg;

    // Word counter: grows on each accepted word, restarts when the chunk is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (take) begin
            count <= '0;
        end else if (in_valid && in_ready) begin
            count <= count + CNT_W'(1);
        end
    end

    // Shift register: newest word enters at the top, first word ends at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (in_valid && in_ready) begin
            shreg <= {in_data, shreg[WORDS*DATA_W-1:DATA_W]};
        end
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(WORDS));
    p_accept_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !take) |=> (count == $past(count) + CNT_W'(1)));
    p_hold_until_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> full);
endmodule

// File: rtl/cmv_cmul.sv
// Complex multiplier: four real products combined into a full-width
// complex product. Purely combinational.
// Assumes: signed two's-complement inputs; OUT_W >= 2*DATA_W+1.
module cmv_cmul #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OUT_W  = 33
) (
    input  logic signed [DATA_W-1:0] a_re,
    input  logic signed [DATA_W-1:0] a_im,
    input  logic signed [DATA_W-1:0] b_re,
    input  logic signed [DATA_W-1:0] b_im,
    output logic signed [OUT_W-1:0]  p_re,
    output logic signed [OUT_W-1:0]  p_im
);
    logic signed [2*DATA_W-1:0] rr, ii, ri, ir;

    // Real partial products and their signed combination.
    always_comb begin
        rr   = a_re * b_re;
        ii   = a_im * b_im;
        ri   = a_re * b_im;
        ir   = a_im * b_re;
        p_re = OUT_W'(rr) - OUT_W'(ii);
        p_im = OUT_W'(ri) + OUT_W'(ir);
    end
endmodule

// File: rtl/cmv_mult_stage.sv
// Multiplier stage: one complex multiplier per chunk point, results
// registered together with a valid flag.
// Assumes: vector and coefficient chunks use the same word layout
// (point k real at word 2k, imaginary at word 2k+1).
module cmv_mult_stage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHUNK  = 8,
    parameter int unsigned PROD_W = 33
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic [2*CHUNK*DATA_W-1:0]     vec_words,
    input  logic [2*CHUNK*DATA_W-1:0]     coef_words,
    output logic                          valid_o,
    output logic [CHUNK*PROD_W-1:0]       prod_re,
    output logic [CHUNK*PROD_W-1:0]       prod_im
);
    for (genvar k = 0; k < CHUNK; k++) begin : g_point
        logic signed [PROD_W-1:0] m_re, m_im;

        cmv_cmul #(.DATA_W(DATA_W), .OUT_W(PROD_W)) u_cmul (
            .a_re (vec_words [(2*k)*DATA_W   +: DATA_W]),
            .a_im (vec_words [(2*k+1)*DATA_W +: DATA_W]),
            .b_re (coef_words[(2*k)*DATA_W   +: DATA_W]),
            .b_im (coef_words[(2*k+1)*DATA_W +: DATA_W]),
            .p_re (m_re),
            .p_im (m_im)
        );

        // Product register for this point, loaded when a chunk pair fires.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_re[k*PROD_W +: PROD_W] <= '0;
                prod_im[k*PROD_W +: PROD_W] <= '0;
            end else if (en) begin
                prod_re[k*PROD_W +: PROD_W] <= m_re;
                prod_im[k*PROD_W +: PROD_W] <= m_im;
            end
        end
    end

    // Stage valid: follows the fire strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= en;
    end

    p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> valid_o);
    p_valid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !valid_o);
endmodule

// File: rtl/cmv_adder_tree.sv
// Registered adder tree: reduces CHUNK leaf values to one sum, with one
// register level per tree level, stored as a heap (node i sums 2i, 2i+1).
// Assumes: CHUNK is a power of two and at least 2.
module cmv_adder_tree #(
    parameter int unsigned CHUNK  = 8,
    parameter int unsigned IN_W   = 33,
    parameter int unsigned SUM_W  = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_i,
    input  logic [CHUNK*IN_W-1:0]       leaves,
    output logic                        valid_o,
    output logic signed [SUM_W-1:0]     sum_o
);
    localparam int unsigned LEVELS = cmv_pkg::cmv_levels(CHUNK);

    logic signed [SUM_W-1:0] node [1:CHUNK-1];
    logic [LEVELS-1:0]       vpipe;

    for (genvar i = 1; i < CHUNK; i++) begin : g_node
        logic signed [SUM_W-1:0] lhs, rhs;
        if (2*i >= CHUNK) begin : g_leaf
            assign lhs = SUM_W'($signed(leaves[(2*i-CHUNK)*IN_W   +: IN_W]));
            assign rhs = SUM_W'($signed(leaves[(2*i+1-CHUNK)*IN_W +: IN_W]));
        end else begin : g_inner
            assign lhs = node[2*i];
            assign rhs = node[2*i+1];
        end

        // Node register: sum of its two children.
        always_ff @(posedge clk) begin
            if (!rst_n) node[i] <= '0;
            else        node[i] <= lhs + rhs;
        end
    end

    // Valid pipeline: one bit per tree level.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else if (LEVELS == 1) vpipe <= LEVELS'(valid_i);
        else        vpipe <= LEVELS'({vpipe, valid_i});
    end

    assign valid_o = vpipe[LEVELS-1];
    assign sum_o   = node[1];

    p_tree_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/cmv_engine.sv
// Chunked complex dot-product engine (top). Pairs vector and coefficient
// chunks, multiplies, reduces through the adder tree and accumulates the
// partial sums of POINTS/CHUNK chunks into one row result.
// Assumes: each row is sent as POINTS points on both streams in lock order.
module cmv_engine #(
    parameter int unsigned DATA_W = cmv_pkg::CMV_DATA_W,
    parameter int unsigned CHUNK  = cmv_pkg::CMV_CHUNK,
    parameter int unsigned POINTS = cmv_pkg::CMV_POINTS,
    parameter int unsigned ACC_W  = cmv_pkg::CMV_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vec_valid,
    input  logic [DATA_W-1:0]        vec_data,
    output logic                     vec_ready,
    input  logic                     coef_valid,
    input  logic [DATA_W-1:0]        coef_data,
    output logic                     coef_ready,
    output logic                     res_valid,
    output logic signed [ACC_W-1:0]  res_re,
    output logic signed [ACC_W-1:0]  res_im
);
    localparam int unsigned PROD_W  = 2*DATA_W + 1;
    localparam int unsigned SUM_W   = PROD_W + cmv_pkg::cmv_levels(CHUNK);
    localparam int unsigned NCHUNK  = POINTS / CHUNK;
    localparam int unsigned CCNT_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int unsigned WBITS   = 2*CHUNK*DATA_W;

    logic              vec_full, coef_full, fire;
    logic [WBITS-1:0]  vec_words, coef_words;
    logic              mul_valid;
    logic [CHUNK*PROD_W-1:0] prod_re, prod_im;
    logic              tre_valid, tim_valid;
    logic signed [SUM_W-1:0] tsum_re, tsum_im;

    logic [CCNT_W-1:0]       chunk_cnt;
    logic signed [ACC_W-1:0] acc_re, acc_im;
    logic signed [ACC_W-1:0] tot_re, tot_im;
    logic                    last_chunk;

    assign fire = vec_full && coef_full;

    cmv_chunk_loader #(.DATA_W(DATA_W), .CHUNK(CHUNK)) u_vec_load (
        .clk(clk), .rst_n(rst_n),
        .in_valid(vec_valid), .in_data(vec_data), .in_ready(vec_ready),
        .take(fire), .full(vec_full), .words(vec_words)
    );

    cmv_chunk_loader #(.DATA_W(DATA_W), .CHUNK(CHUNK)) u_coef_load (
        .clk(clk), .rst_n(rst_n),
        .in_valid(coef_valid), .in_data(coef_data), .in_ready(coef_ready),
        .take(fire), .full(coef_full), .words(coef_words)
    );

    cmv_mult_stage #(.DATA_W(DATA_W), .CHUNK(CHUNK), .PROD_W(PROD_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .en(fire),
        .vec_words(vec_words), .coef_words(coef_words),
        .valid_o(mul_valid), .prod_re(prod_re), .prod_im(prod_im)
    );

    cmv_adder_tree #(.CHUNK(CHUNK), .IN_W(PROD_W), .SUM_W(SUM_W)) u_tree_re (
        .clk(clk), .rst_n(rst_n), .valid_i(mul_valid), .leaves(prod_re),
        .valid_o(tre_valid), .sum_o(tsum_re)
    );

    cmv_adder_tree #(.CHUNK(CHUNK), .IN_W(PROD_W), .SUM_W(SUM_W)) u_tree_im (
        .clk(clk), .rst_n(rst_n), .valid_i(mul_valid), .leaves(prod_im),
        .valid_o(tim_valid), .sum_o(tsum_im)
    );

    // Running totals: restart from the tree output on the first chunk of a row.
    always_comb begin
        last_chunk = (chunk_cnt == CCNT_W'(NCHUNK - 1));
        if (chunk_cnt == '0) begin
            tot_re = ACC_W'(tsum_re);
            tot_im = ACC_W'(tsum_im);
        end else begin
            tot_re = acc_re + ACC_W'(tsum_re);
            tot_im = acc_im + ACC_W'(tsum_im);
        end
    end

    // Accumulator and chunk counter: advance on every reduced chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_cnt <= '0;
            acc_re    <= '0;
            acc_im    <= '0;
        end else if (tre_valid) begin
            acc_re    <= tot_re;
            acc_im    <= tot_im;
            chunk_cnt <= last_chunk ? '0 : chunk_cnt + CCNT_W'(1);
        end
    end

    // Result register and strobe: loaded once per row, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_re    <= '0;
            res_im    <= '0;
        end else begin
            res_valid <= tre_valid && last_chunk;
            if (tre_valid && last_chunk) begin
                res_re <= tot_re;
                res_im <= tot_im;
            end
        end
    end

    p_trees_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tre_valid == tim_valid);
    p_chunk_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_cnt <= CCNT_W'(NCHUNK - 1));
    p_fire_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (vec_ready && coef_ready));
    p_wait_partner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_full && !coef_full) |-> !vec_ready);
    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_re) && $stable(res_im)));
endmodule

// File: tb/cmv_engine_test.sv
module cmv_engine_test;
    localparam int NPTS  = 256;
    localparam int ACCW  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vec_valid = 1'b0, coef_valid = 1'b0;
    logic [15:0] vec_data = '0, coef_data = '0;
    logic vec_ready, coef_ready, res_valid;
    logic signed [ACCW-1:0] res_re, res_im;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide_pulses = 0;
    bit prev_valid = 1'b0;
    bit done = 1'b0;

    int vr [NPTS];
    int vi [NPTS];
    int cr [NPTS];
    int ci [NPTS];
    logic signed [ACCW-1:0] exp_re, exp_im;

    always #10 clk = ~clk;

    cmv_engine uut (
        .clk(clk), .rst_n(rst_n),
        .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
        .coef_valid(coef_valid), .coef_data(coef_data), .coef_ready(coef_ready),
        .res_valid(res_valid), .res_re(res_re), .res_im(res_im)
    );

    // Pulse monitor for R4.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) pulses++;
            if (res_valid && prev_valid) wide_pulses++;
            prev_valid = res_valid;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Expected row result from the requirement R3 formula, wrapped to 40 bits.
    task automatic compute_expected();
        longint sr = 0;
        longint si = 0;
        for (int k = 0; k < NPTS; k++) begin
            sr += longint'(vr[k]) * cr[k] - longint'(vi[k]) * ci[k];
            si += longint'(vr[k]) * ci[k] + longint'(vi[k]) * cr[k];
        end
        exp_re = sr[ACCW-1:0];
        exp_im = si[ACCW-1:0];
    endtask

    function automatic int rnd16();
        logic signed [15:0] t;
        t = 16'($urandom);
        return int'(t);
    endfunction

    task automatic fill_random(input int mag);
        for (int k = 0; k < NPTS; k++) begin
            if (mag == 0) begin
                vr[k] = rnd16(); vi[k] = rnd16(); cr[k] = rnd16(); ci[k] = rnd16();
            end else begin
                vr[k] = $urandom_range(2*mag, 0) - mag; vi[k] = $urandom_range(2*mag, 0) - mag;
                cr[k] = $urandom_range(2*mag, 0) - mag; ci[k] = $urandom_range(2*mag, 0) - mag;
            end
        end
    endtask

    function automatic logic [15:0] word_of(input bit is_coef, input int w);
        int p = w / 2;
        if (is_coef) return (w % 2 == 0) ? 16'(cr[p]) : 16'(ci[p]);
        return (w % 2 == 0) ? 16'(vr[p]) : 16'(vi[p]);
    endfunction

    // Drives words [w0, w1) on one stream; random gaps carry garbage data (R8).
    task automatic drive(input bit is_coef, input int gap_max, input int w0, input int w1);
        for (int w = w0; w < w1; w++) begin
            int gap = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (is_coef) begin coef_valid = 1'b0; coef_data = 16'($urandom); end
                else         begin vec_valid  = 1'b0; vec_data  = 16'($urandom); end
            end
            @(negedge clk);
            if (is_coef) begin coef_valid = 1'b1; coef_data = word_of(1'b1, w); end
            else         begin vec_valid  = 1'b1; vec_data  = word_of(1'b0, w); end
            while (!(is_coef ? coef_ready : vec_ready)) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        if (is_coef) begin coef_valid = 1'b0; coef_data = 16'($urandom); end
        else         begin vec_valid  = 1'b0; vec_data  = 16'($urandom); end
    endtask

    task automatic wait_and_check(input string req);
        int t = 0;
        while (!res_valid && t < 4000) begin @(negedge clk); t++; end
        chk(res_valid, req, "result strobe seen", res_valid, 1);
        chk(res_re == exp_re, req, "real part", res_re, exp_re);
        chk(res_im == exp_im, req, "imag part", res_im, exp_im);
    endtask

    task automatic check_hold();
        repeat (7) @(negedge clk);
        chk(res_re == exp_re, "R9", "real held", res_re, exp_re);
        chk(res_im == exp_im, "R9", "imag held", res_im, exp_im);
    endtask

    task automatic run_row(input int gap_v, input int gap_c, input string req);
        compute_expected();
        fork
            drive(1'b0, gap_v, 0, 2*NPTS);
            drive(1'b1, gap_c, 0, 2*NPTS);
        join
        wait_and_check(req);
        check_hold();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));

        // R7: reset state.
        repeat (3) @(negedge clk);
        chk(vec_ready == 1'b1, "R7", "vec_ready in reset", vec_ready, 1);
        chk(coef_ready == 1'b1, "R7", "coef_ready in reset", coef_ready, 1);
        chk(res_valid == 1'b0, "R7", "res_valid in reset", res_valid, 0);
        chk(res_re == 0 && res_im == 0, "R7", "result in reset", res_re, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vec_ready && coef_ready && !res_valid, "R7", "after reset", res_valid, 0);

        // R3: all parts at the most negative value; imaginary total hits 2^39 and wraps.
        for (int k = 0; k < NPTS; k++) begin
            vr[k] = -32768; vi[k] = -32768; cr[k] = -32768; ci[k] = -32768;
        end
        run_row(0, 0, "R3");

        // R5: lockstep streams, latency from the final accepted word.
        fill_random(0);
        compute_expected();
        fork
            drive(1'b0, 0, 0, 2*NPTS);
            drive(1'b1, 0, 0, 2*NPTS);
        join
        begin
            int k = 1;
            while (!res_valid && k < 50) begin @(negedge clk); k++; end
            chk(k == 6, "R5", "negedges to result", k, 6);
        end
        chk(res_re == exp_re && res_im == exp_im, "R5", "lockstep row value", res_re, exp_re);
        check_hold();

        // R2: vector chunk alone must stall until the coefficient chunk arrives.
        fill_random(0);
        compute_expected();
        drive(1'b0, 0, 0, 16);
        repeat (8) @(negedge clk);
        chk(vec_ready == 1'b0, "R2", "vec_ready while partner missing", vec_ready, 0);
        chk(coef_ready == 1'b1, "R2", "coef_ready while partner missing", coef_ready, 1);
        chk(res_valid == 1'b0, "R2", "no result mid-row", res_valid, 0);
        fork
            drive(1'b0, 2, 16, 2*NPTS);
            drive(1'b1, 5, 0, 2*NPTS);
        join
        wait_and_check("R2");
        check_hold();

        // R1/R6/R8: random rows with random gaps on both streams.
        for (int r = 0; r < 5; r++) begin
            fill_random(0);
            run_row(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), "R6");
        end

        // R1: small magnitudes, vector stream much slower than coefficients.
        fill_random(3);
        run_row(4, 0, "R1");

        // R4: one single-cycle strobe per row (9 rows sent).
        repeat (10) @(negedge clk);
        chk(pulses == 9, "R4", "result pulses", pulses, 9);
        chk(wide_pulses == 0, "R4", "multi-cycle pulses", wide_pulses, 0);

        finish_run();
    end
endmodule